// File: doc/BRIEF.md
# Two-wire DAC control register target

This block is the digital front end of a serial-controlled converter. It listens on a two-wire serial bus (SCL clock, SDA data, both open-drain). It answers either its own 7-bit address, chosen by two three-level strap inputs, or a shared broadcast address. It holds the 16-bit converter control word that the bus writes and reads. The bus lines are oversampled on the system clock through a two-flop synchronizer. The block drives SDA only by asserting an enable that pulls the line low.

A write carries one or more two-byte words, most significant byte first. Each complete word loads the control register and raises a one-cycle update strobe in the acknowledge slot after its second byte, so the analog side can switch its output at that instant. The broadcast address lets one write reach every such device on the bus together. A read returns the register as two bytes. The strap-selected address is frozen after the first correct own-address match, and stays so until reset.

Top module: `i2c_dac_target`

## Requirements
- R1: A start or repeated start (SDA falling while SCL is high) begins reception of an address byte from any state. A stop (SDA rising while SCL is high) returns the block to idle with SDA released. A repeated start partway through a write word discards the partial word.
- R2: The address byte is seven address bits, MSB first, then a direction bit (0 = write, 1 = read). The block pulls SDA low in the following acknowledge slot only when the address matches, and otherwise leaves SDA released for the rest of the transaction.
- R3: Strap codes are 2'b00 = tied low, 2'b01 = floating, 2'b10 = tied high, with 2'b11 treated as floating. The high strap picks the upper five address bits: floating 00011, low 00010, high 10011. The low strap picks the lower two bits: floating 00, low 01, high 10.
- R4: A write to the broadcast address 1001000 is acknowledged and updates the register exactly like a write to the own address.
- R5: A read to the broadcast address is not acknowledged.
- R6: After the first acknowledged own-address match, the address is frozen and later strap changes have no effect until reset.
- R7: A write word is an upper byte and then a lower byte, each acknowledged. The register (bits 15:14 forced to 0, bits 13:12 power-down mode, bits 11:0 code) and a one-cycle `dac_update` pulse change only at the SCL rise of the acknowledge after the lower byte.
- R8: Further byte pairs before a stop or repeated start each form a new word and a new update.
- R9: A read sends the upper byte and then the lower byte, MSB first. After a not-acknowledge from the controller, or after the lower byte, SDA stays released until the next start or stop.
- R10: After reset the register is 0x0000, `dac_update` is low, SDA is released and the address is unfrozen.
- R11: The SDA pull-down enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, models a power cycle |
| scl_in | input | 1 | Serial clock line as seen on the pad |
| sda_in | input | 1 | Serial data line as seen on the pad |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_hi | input | 2 | Three-level code of the upper address strap |
| strap_lo | input | 2 | Three-level code of the lower address strap |
| dac_word | output | 16 | Current control register contents |
| dac_update | output | 1 | One-cycle pulse when a new word is loaded |

## Verification
On every cycle, the assertions check four things. The pull-down enable changes only while SCL is low. The register value changes only together with a single-cycle update pulse. A stop releases SDA. Once the address is frozen, it never unfreezes and never changes. The following can only be shown by the bench's bus-level scenarios: the address decode for every strap combination, the acknowledge and not-acknowledge choices for own, broadcast and foreign addresses, byte ordering on writes and reads, back-to-back words, freezing of the address against later strap changes, and the discarding of a word cut short by a repeated start.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;

    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int CNT_W   = $clog2(BYTE_W) + 1;
    localparam int LIVE_HI = 6;

    localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'b1001000;

    localparam logic [1:0] STRAP_LOW  = 2'b00;
    localparam logic [1:0] STRAP_HIGH = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } link_state_t;

    typedef struct packed {
        link_state_t        state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               rw;
        logic               low;
        logic               rdack;
        logic [BYTE_W-1:0]  upper;
        logic [WORD_W-1:0]  regv;
        logic               upd;
        logic               oe;
    } link_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_pipe = {sync_q.scl_pipe[STAGES-2:0], scl_raw};
        sync_d.sda_pipe = {sync_q.sda_pipe[STAGES-2:0], sda_raw};
        sync_d.scl_prev = sync_q.scl_pipe[STAGES-1];
        sync_d.sda_prev = sync_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_s     = sync_q.scl_pipe[STAGES-1];
    assign sda_s     = sync_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign start_det = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_addr_select.sv
module i2c_addr_select
    import i2c_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_hi,
    input  logic [1:0]        strap_lo,
    input  logic              lock_req,
    output logic [ADDR_W-1:0] own_addr,
    output logic              locked
);

    typedef struct packed {
        logic              lock;
        logic [ADDR_W-1:0] addr;
    } sel_regs_t;

    sel_regs_t sel_d, sel_q;
    logic [4:0] pre_bits;
    logic [1:0] suf_bits;
    logic [ADDR_W-1:0] strap_addr;

    always_comb begin
        unique case (strap_hi)
            STRAP_LOW:  pre_bits = 5'b00010;
            STRAP_HIGH: pre_bits = 5'b10011;
            default:    pre_bits = 5'b00011;
        endcase
        unique case (strap_lo)
            STRAP_LOW:  suf_bits = 2'b01;
            STRAP_HIGH: suf_bits = 2'b10;
            default:    suf_bits = 2'b00;
        endcase
        strap_addr = {pre_bits, suf_bits};

        sel_d = sel_q;
        if (!sel_q.lock && lock_req) begin
            sel_d.lock = 1'b1;
            sel_d.addr = strap_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign own_addr = sel_q.lock ? sel_q.addr : strap_addr;
    assign locked   = sel_q.lock;

    // R6: once frozen, the address stays frozen and unchanged
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_q.lock) |-> sel_q.lock);
    a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q.lock && $past(sel_q.lock)) |-> $stable(own_addr));

endmodule

// File: rtl/i2c_dac_target.sv
module i2c_dac_target
    import i2c_dac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [1:0]        strap_hi,
    input  logic [1:0]        strap_lo,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_update
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic lock_req, locked;
    logic [ADDR_W-1:0] own_addr;
    logic own_hit, bc_hit;

    link_regs_t lk_d, lk_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_addr_select i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_hi (strap_hi),
        .strap_lo (strap_lo),
        .lock_req (lock_req),
        .own_addr (own_addr),
        .locked   (locked)
    );

    assign own_hit = (lk_q.sh[BYTE_W-1:1] == own_addr);
    assign bc_hit  = (lk_q.sh[BYTE_W-1:1] == BCAST_ADDR) && !lk_q.sh[0];

    always_comb begin
        lk_d     = lk_q;
        lk_d.upd = 1'b0;
        lock_req = 1'b0;
        if (stop_det) begin
            lk_d.state = ST_IDLE;
            lk_d.oe    = 1'b0;
        end else if (start_det) begin
            lk_d.state = ST_ADDR;
            lk_d.cnt   = '0;
            lk_d.oe    = 1'b0;
        end else begin
            unique case (lk_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        lk_d.sh  = {lk_q.sh[BYTE_W-2:0], sda_s};
                        lk_d.cnt = lk_q.cnt + 1'b1;
                    end else if (scl_fall && lk_q.cnt == CNT_W'(BYTE_W)) begin
                        lk_d.rw = lk_q.sh[0];
                        if (own_hit || bc_hit) begin
                            lk_d.oe    = 1'b1;
                            lk_d.state = ST_AACK;
                            lock_req   = own_hit;
                        end else begin
                            lk_d.state = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        lk_d.cnt = '0;
                        lk_d.low = 1'b0;
                        if (lk_q.rw) begin
                            lk_d.state = ST_RDATA;
                            lk_d.sh    = lk_q.regv[WORD_W-1:BYTE_W];
                            lk_d.oe    = ~lk_q.regv[WORD_W-1];
                        end else begin
                            lk_d.state = ST_WDATA;
                            lk_d.oe    = 1'b0;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        lk_d.sh  = {lk_q.sh[BYTE_W-2:0], sda_s};
                        lk_d.cnt = lk_q.cnt + 1'b1;
                    end else if (scl_fall && lk_q.cnt == CNT_W'(BYTE_W)) begin
                        lk_d.oe    = 1'b1;
                        lk_d.state = ST_WACK;
                        if (!lk_q.low) begin
                            lk_d.upper = lk_q.sh;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_rise && lk_q.low) begin
                        lk_d.regv = {{(BYTE_W-LIVE_HI){1'b0}},
                                     lk_q.upper[LIVE_HI-1:0], lk_q.sh};
                        lk_d.upd  = 1'b1;
                    end else if (scl_fall) begin
                        lk_d.oe    = 1'b0;
                        lk_d.cnt   = '0;
                        lk_d.low   = ~lk_q.low;
                        lk_d.state = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        lk_d.cnt = lk_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (lk_q.cnt == CNT_W'(BYTE_W)) begin
                            lk_d.oe    = 1'b0;
                            lk_d.state = ST_RACK;
                        end else begin
                            lk_d.sh = {lk_q.sh[BYTE_W-2:0], 1'b0};
                            lk_d.oe = ~lk_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        lk_d.rdack = ~sda_s;
                    end else if (scl_fall) begin
                        if (lk_q.rdack && !lk_q.low) begin
                            lk_d.state = ST_RDATA;
                            lk_d.low   = 1'b1;
                            lk_d.cnt   = '0;
                            lk_d.sh    = lk_q.regv[BYTE_W-1:0];
                            lk_d.oe    = ~lk_q.regv[BYTE_W-1];
                        end else begin
                            lk_d.state = ST_SKIP;
                        end
                    end
                end
                default: begin
                    lk_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q       <= '0;
            lk_q.state <= ST_IDLE;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign sda_pull   = lk_q.oe;
    assign dac_word   = lk_q.regv;
    assign dac_update = lk_q.upd;

    // R11: the pull-down enable switches only while SCL is low
    a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !$past(scl_s));
    // R7: the register only moves together with the update strobe
    a_r7_word_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_word != $past(dac_word)) |-> dac_update);
    // R7: the strobe lasts one cycle
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update |=> !dac_update);
    // R1: a stop always releases SDA
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);
    // R6: freezing happens only through an own-address match
    a_r6_lock_by_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(lock_req));

endmodule

// File: tb/test_i2c_dac_target.sv
module test_i2c_dac_target;

    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap_hi = 2'b01;
    logic [1:0] strap_lo = 2'b01;
    logic sda_pull, dac_update;
    logic [15:0] dac_word;
    wire  sda_bus = sda_m & ~sda_pull;

    int checks = 0;
    int failures = 0;
    int upd_cnt = 0;
    int pull_viol = 0;
    logic pull_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_dac_target i_i2c_dac_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl),
        .sda_in     (sda_bus),
        .sda_pull   (sda_pull),
        .strap_hi   (strap_hi),
        .strap_lo   (strap_lo),
        .dac_word   (dac_word),
        .dac_update (dac_update)
    );

    always @(posedge clk) begin
        if (dac_update) upd_cnt <= upd_cnt + 1;
        pull_prev <= sda_pull;
        if (rst_n && sda_pull !== pull_prev && scl) pull_viol <= pull_viol + 1;
    end

    // {strap_hi, strap_lo, address, expected ack}
    localparam logic [11:0] VEC [12] = '{
        {2'b01, 2'b01, 7'b0001100, 1'b1},
        {2'b01, 2'b00, 7'b0001101, 1'b1},
        {2'b01, 2'b10, 7'b0001110, 1'b1},
        {2'b00, 2'b01, 7'b0001000, 1'b1},
        {2'b00, 2'b00, 7'b0001001, 1'b1},
        {2'b00, 2'b10, 7'b0001010, 1'b1},
        {2'b10, 2'b01, 7'b1001100, 1'b1},
        {2'b10, 2'b00, 7'b1001101, 1'b1},
        {2'b10, 2'b10, 7'b1001110, 1'b1},
        {2'b11, 2'b11, 7'b0001100, 1'b1},
        {2'b01, 2'b01, 7'b0001101, 1'b0},
        {2'b10, 2'b10, 7'b1001111, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        int u0;

        do_reset();
        // R10: reset state
        check("R10 reset word", dac_word, 32'h0);
        check("R10 reset strobe", dac_update, 1'b0);
        check("R10 reset sda released", sda_pull, 1'b0);

        // R2 R3: address decode table, one reset per entry
        for (int i = 0; i < 12; i++) begin
            strap_hi = VEC[i][11:10];
            strap_lo = VEC[i][9:8];
            do_reset();
            bus_start();
            send_byte({VEC[i][7:1], 1'b0}, ack);
            check($sformatf("R3 R2 address vector %0d", i), ack, VEC[i][0]);
            bus_stop();
        end

        // R7 R8: two back-to-back words, own address
        strap_hi = 2'b01; strap_lo = 2'b01;
        do_reset();
        u0 = upd_cnt;
        bus_start();
        send_byte(8'b0001_1000, ack);
        check("R2 own write ack", ack, 1'b1);
        send_byte(8'hDA, ack);
        check("R7 upper byte ack", ack, 1'b1);
        check("R7 no update after upper byte", dac_word, 32'h0);
        send_byte(8'hBC, ack);
        check("R7 lower byte ack", ack, 1'b1);
        check("R7 word with top bits cleared", dac_word, 32'h1ABC);
        check("R7 one strobe", upd_cnt - u0, 1);
        send_byte(8'h23, ack);
        send_byte(8'h45, ack);
        check("R8 second word", dac_word, 32'h2345);
        check("R8 second strobe", upd_cnt - u0, 2);
        bus_stop();
        check("R1 stop releases", sda_pull, 1'b0);

        // R9: read back
        bus_start();
        send_byte(8'b0001_1001, ack);
        check("R9 read ack", ack, 1'b1);
        recv_byte(rb, 1'b1);
        check("R9 upper byte", rb, 8'h23);
        recv_byte(rb, 1'b0);
        check("R9 lower byte", rb, 8'h45);
        check("R9 released after nack", sda_pull, 1'b0);
        tick(Q);
        check("R9 still released", sda_bus, 1'b1);
        bus_stop();

        // R6: frozen address ignores strap changes
        strap_hi = 2'b10; strap_lo = 2'b10;
        bus_start();
        send_byte(8'b1001_1100, ack);
        check("R6 new strap address ignored", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'b0001_1000, ack);
        check("R6 frozen address still acked", ack, 1'b1);
        bus_stop();

        // R4 R5: broadcast
        bus_start();
        send_byte(8'b1001_0000, ack);
        check("R4 broadcast write ack", ack, 1'b1);
        send_byte(8'h00, ack);
        send_byte(8'h7F, ack);
        check("R4 broadcast update", dac_word, 32'h007F);
        bus_stop();
        bus_start();
        send_byte(8'b1001_0001, ack);
        check("R5 broadcast read nack", ack, 1'b0);
        recv_bit(ack);
        check("R5 no data driven", ack, 1'b1);
        bus_stop();

        // R1: repeated start drops a half word
        u0 = upd_cnt;
        bus_start();
        send_byte(8'b0001_1000, ack);
        send_byte(8'h31, ack);
        bus_rstart();
        send_byte(8'b0001_1001, ack);
        check("R1 repeated start read ack", ack, 1'b1);
        recv_byte(rb, 1'b1);
        check("R1 partial word dropped upper", rb, 8'h00);
        recv_byte(rb, 1'b0);
        check("R1 partial word dropped lower", rb, 8'h7F);
        check("R1 no strobe for partial word", upd_cnt - u0, 0);
        bus_stop();

        // R6 R10: reset unfreezes the address
        do_reset();
        bus_start();
        send_byte(8'b1001_1100, ack);
        check("R6 reset unfreezes address", ack, 1'b1);
        bus_stop();

        check("R11 pull changes only with scl low", pull_viol, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule